// File: doc/BRIEF.md
# GPIO pad configuration register bank

This block holds the software-visible control state for a small group of general-purpose I/O pads. Every pad owns a 16-byte address window holding two words. The configuration word selects the pad function, the pull direction and strength, and open-drain output mode. The value word holds the output level and two active-low enables, one for the output driver and one for the input receiver.

Software reaches both words through a plain 32-bit register port. Writes take effect on the clock edge where `we_i` is high. Reads are combinational from `addr_i`. The block drives the pad ring directly with a level, an active-low output enable and an active-low input enable for each pad. It also forwards the function, pull and open-drain fields as static outputs.

Pad input levels pass through a two-flop synchroniser. While a pad's input is enabled, the synchronised level is what software reads back in the value word.

Top module: `gpio_pad_bank`

## Requirements
- R1: Pad n's configuration word is at byte address 16·n + 0x0 and its value word is at 16·n + 0x8. A write to one pad's word changes no other pad's words.
- R2: The configuration word stores bits 2:0 (function select), bits 8:7 (pull direction), bits 10:9 (pull strength) and bit 31 (open-drain), and every other bit reads 0. These fields appear on `func_sel_o`, `pull_dir_o`, `pull_str_o` and `open_drain_o` from the cycle after the write.
- R3: The value word stores bit 0 (level), bit 1 (output enable, active low) and bit 2 (input enable, active low). Bits 31:3 always read 0.
- R4: During and after reset, every configuration word reads 0 and every value word reads 0x6. All `pad_oe_no` and `pad_ie_no` bits are 1.
- R5: `pad_out_o[n]` equals the stored level. `pad_oe_no[n]` is 0 only when all of the following hold: value bit 1 is 0, the function select equals pad n's GPIO code, and the pad is not an open-drain pad holding level 1.
- R6: For an open-drain pad, level 1 releases the pad (`pad_oe_no` = 1) and level 0 drives it low.
- R7: `pad_ie_no[n]` is 0 only when value bit 2 is 0 and the function select equals pad n's GPIO code.
- R8: While value bit 2 is 0, read bit 0 returns the synchronised pad input. A change on `pad_in_i` becomes visible after exactly two rising clock edges. While value bit 2 is 1, read bit 0 returns the last written level.
- R9: Reads of any address other than the mapped words (other offsets inside a window, misaligned addresses, windows beyond the last pad) return 0. Writes to such addresses change no register.
- R10: Each pad has its own 3-bit GPIO code, set by parameter. The GPIO condition in R5 and R7 compares against that pad's code, so a pad with a non-zero code is inert at function 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pad_in_i | input | NUM_PADS | Pad input levels, asynchronous |
| pad_out_o | output | NUM_PADS | Pad output levels |
| pad_oe_no | output | NUM_PADS | Pad output driver enable, active low |
| pad_ie_no | output | NUM_PADS | Pad input receiver enable, active low |
| func_sel_o | output | 3·NUM_PADS | Function select per pad |
| pull_dir_o | output | 2·NUM_PADS | Pull direction per pad (1 up, 2 down) |
| pull_str_o | output | 2·NUM_PADS | Pull strength code per pad |
| open_drain_o | output | NUM_PADS | Open-drain mode per pad |

## Verification
The bench builds the block with four pads and an 8-bit address, and gives pad 3 a GPIO code of 1 while the others keep code 0. With four pads, every window can be swept, along with an unmapped window directly above the last pad. The non-zero code on pad 3 lets every value word combination be crossed with open-drain mode and with matching and mismatching function selects. The bench also times the two-edge input latency directly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [3:0]  CONF_OFS   = 4'h0;
  localparam logic [3:0]  VAL_OFS    = 4'h8;
  localparam logic [31:0] CONF_WMASK = 32'h8000_0787;

  typedef struct packed {
    logic       od;
    logic [1:0] pull_str;
    logic [1:0] pull_dir;
    logic [2:0] func;
  } pad_conf_t;

  typedef struct packed {
    logic ie_n;
    logic oe_n;
    logic level;
  } pad_val_t;

  localparam pad_conf_t CONF_RST = '0;
  localparam pad_val_t  VAL_RST  = 3'b110;

  function automatic pad_conf_t conf_from_word(input logic [31:0] w);
    pad_conf_t c;
    c.od       = w[31];
    c.pull_str = w[10:9];
    c.pull_dir = w[8:7];
    c.func     = w[2:0];
    return c;
  endfunction

  function automatic logic [31:0] conf_to_word(input pad_conf_t c);
    return {c.od, 20'b0, c.pull_str, c.pull_dir, 4'b0, c.func};
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PADS = 8,
  parameter int unsigned ADDR_W   = 10,
  localparam int unsigned IDX_W   = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_PADS-1:0] hit_conf_o,
  output logic [NUM_PADS-1:0] hit_val_o
);
  logic [IDX_W-1:0] idx;
  logic [3:0]       ofs;

  assign idx = addr_i[ADDR_W-1:4];
  assign ofs = addr_i[3:0];

  for (genvar n = 0; n < NUM_PADS; n++) begin : g_hit
    logic sel;
    assign sel           = (idx == IDX_W'(n));
    assign hit_conf_o[n] = sel && (ofs == CONF_OFS);
    assign hit_val_o[n]  = sel && (ofs == VAL_OFS);
  end
endmodule

// File: rtl/gpio_pad_slice.sv
module gpio_pad_slice
  import gpio_bank_pkg::*;
#(
  parameter logic [2:0] GPIO_CODE = 3'd0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        conf_we_i,
  input  logic        val_we_i,
  input  pad_conf_t   conf_wr_i,
  input  pad_val_t    val_wr_i,
  input  logic        pad_in_i,
  output pad_conf_t   conf_o,
  output logic [31:0] rd_conf_o,
  output logic [31:0] rd_val_o,
  output logic        pad_out_o,
  output logic        pad_oe_no,
  output logic        pad_ie_no
);
  pad_conf_t conf_q;
  pad_val_t  val_q;
  logic      in_sync;
  logic      gpio_mode;
  logic      drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conf_q <= CONF_RST;
      val_q  <= VAL_RST;
    end else begin
      if (conf_we_i) conf_q <= conf_wr_i;
      if (val_we_i)  val_q  <= val_wr_i;
    end
  end

  gpio_sync2 #(.W(1)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (in_sync)
  );

  assign gpio_mode = (conf_q.func == GPIO_CODE);
  // open-drain: a high level releases the pad
  assign drive     = gpio_mode && !val_q.oe_n && !(conf_q.od && val_q.level);

  assign pad_out_o = val_q.level;
  assign pad_oe_no = !drive;
  assign pad_ie_no = !(gpio_mode && !val_q.ie_n);

  assign conf_o    = conf_q;
  assign rd_conf_o = conf_to_word(conf_q);
  assign rd_val_o  = {29'b0, val_q.ie_n, val_q.oe_n,
                      val_q.ie_n ? val_q.level : in_sync};
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PADS          = 8,
  parameter int unsigned ADDR_W            = 10,
  parameter logic [3*NUM_PADS-1:0] GPIO_CODES = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  we_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PADS-1:0]   pad_in_i,
  output logic [NUM_PADS-1:0]   pad_out_o,
  output logic [NUM_PADS-1:0]   pad_oe_no,
  output logic [NUM_PADS-1:0]   pad_ie_no,
  output logic [3*NUM_PADS-1:0] func_sel_o,
  output logic [2*NUM_PADS-1:0] pull_dir_o,
  output logic [2*NUM_PADS-1:0] pull_str_o,
  output logic [NUM_PADS-1:0]   open_drain_o
);
  logic [NUM_PADS-1:0] hit_conf, hit_val;
  logic [31:0]         rd_conf [NUM_PADS];
  logic [31:0]         rd_val  [NUM_PADS];
  pad_conf_t           conf_wr;
  pad_val_t            val_wr;
  logic                unused_wdata;

  assign conf_wr      = conf_from_word(wdata_i);
  assign val_wr       = wdata_i[2:0];
  assign unused_wdata = ^{wdata_i[30:11], wdata_i[6:3]};

  gpio_bank_decode #(
    .NUM_PADS (NUM_PADS),
    .ADDR_W   (ADDR_W)
  ) decode_i (
    .addr_i     (addr_i),
    .hit_conf_o (hit_conf),
    .hit_val_o  (hit_val)
  );

  for (genvar n = 0; n < NUM_PADS; n++) begin : g_pad
    pad_conf_t conf;

    gpio_pad_slice #(
      .GPIO_CODE (GPIO_CODES[3*n +: 3])
    ) slice_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .conf_we_i (we_i && hit_conf[n]),
      .val_we_i  (we_i && hit_val[n]),
      .conf_wr_i (conf_wr),
      .val_wr_i  (val_wr),
      .pad_in_i  (pad_in_i[n]),
      .conf_o    (conf),
      .rd_conf_o (rd_conf[n]),
      .rd_val_o  (rd_val[n]),
      .pad_out_o (pad_out_o[n]),
      .pad_oe_no (pad_oe_no[n]),
      .pad_ie_no (pad_ie_no[n])
    );

    assign func_sel_o[3*n +: 3]  = conf.func;
    assign pull_dir_o[2*n +: 2]  = conf.pull_dir;
    assign pull_str_o[2*n +: 2]  = conf.pull_str;
    assign open_drain_o[n]       = conf.od;
  end

  // hits are one-hot; unmapped addresses leave zero
  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NUM_PADS; n++) begin
      if (hit_conf[n]) rdata_o = rdata_o | rd_conf[n];
      if (hit_val[n])  rdata_o = rdata_o | rd_val[n];
    end
  end
endmodule

// File: rtl/gpio_pad_bank_chk.sv
module gpio_pad_bank_chk #(
  parameter int unsigned NUM_PADS          = 8,
  parameter int unsigned ADDR_W            = 10,
  parameter logic [3*NUM_PADS-1:0] GPIO_CODES = '0
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-1:0]     addr_i,
  input logic                  we_i,
  input logic [31:0]           wdata_i,
  input logic [31:0]           rdata_o,
  input logic [NUM_PADS-1:0]   pad_out_o,
  input logic [NUM_PADS-1:0]   pad_oe_no,
  input logic [NUM_PADS-1:0]   pad_ie_no,
  input logic [3*NUM_PADS-1:0] func_sel_o,
  input logic [NUM_PADS-1:0]   open_drain_o
);
  logic mapped;
  assign mapped = ((addr_i[3:0] == 4'h0) || (addr_i[3:0] == 4'h8)) &&
                  (int'(addr_i[ADDR_W-1:4]) < NUM_PADS);

  always @(posedge clk_i) begin
    if (!rst_ni)
      assert_reset_hiz_R4: assert (pad_oe_no == '1 && pad_ie_no == '1);
    else if (!mapped)
      assert_unmapped_zero_R9: assert (rdata_o == 32'h0);
  end

  assert_val_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mapped && addr_i[3:0] == 4'h8) |-> (rdata_o[31:3] == '0));

  for (genvar n = 0; n < NUM_PADS; n++) begin : g_chk
    assert_conf_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(16 * n)) |=>
      (func_sel_o[3*n +: 3] == $past(wdata_i[2:0]) && open_drain_o[n] == $past(wdata_i[31])));

    assert_drive_needs_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pad_oe_no[n] |-> (func_sel_o[3*n +: 3] == GPIO_CODES[3*n +: 3]));

    assert_od_never_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (open_drain_o[n] && !pad_oe_no[n]) |-> !pad_out_o[n]);

    assert_input_needs_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pad_ie_no[n] |-> (func_sel_o[3*n +: 3] == GPIO_CODES[3*n +: 3]));
  end
endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(
  .NUM_PADS   (NUM_PADS),
  .ADDR_W     (ADDR_W),
  .GPIO_CODES (GPIO_CODES)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .we_i         (we_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .pad_out_o    (pad_out_o),
  .pad_oe_no    (pad_oe_no),
  .pad_ie_no    (pad_ie_no),
  .func_sel_o   (func_sel_o),
  .open_drain_o (open_drain_o)
);

// File: tb/gpio_pad_bank_tb_top.sv
module gpio_pad_bank_tb_top;
  localparam int unsigned NP = 4;
  localparam int unsigned AW = 8;
  localparam logic [3*NP-1:0] CODES = 12'b001_000_000_000;
  localparam logic [31:0] CMASK = 32'h8000_0787;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe_n, pad_ie_n, od;
  logic [3*NP-1:0] func;
  logic [2*NP-1:0] pdir, pstr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_pad_bank #(.NUM_PADS(NP), .ADDR_W(AW), .GPIO_CODES(CODES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_no(pad_oe_n),
    .pad_ie_no(pad_ie_n), .func_sel_o(func), .pull_dir_o(pdir), .pull_str_o(pstr),
    .open_drain_o(od)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [AW-1:0] ca(input int p);
    return AW'(16 * p);
  endfunction
  function automatic logic [AW-1:0] va(input int p);
    return AW'(16 * p + 8);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] cw [NP];
    logic [31:0] vw [NP];
    repeat (3) @(negedge clk);
    chk("R4 oe in reset", 32'(pad_oe_n), 32'hF);
    chk("R4 ie in reset", 32'(pad_ie_n), 32'hF);
    rst_n = 1'b1;
    for (int p = 0; p < NP; p++) begin
      rd(ca(p), d); chk("R4 conf reset", d, 32'h0);
      rd(va(p), d); chk("R4 val reset", d, 32'h6);
    end
    chk("R4 oe after reset", 32'(pad_oe_n), 32'hF);

    // R2: configuration field sweep
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] w;
        w = 32'h9E37_79B9 * 32'(k + 1) + 32'(p);
        wr(ca(p), w);
        rd(ca(p), d);
        chk("R2 conf readback", d, w & CMASK);
        chk("R2 func_sel_o", 32'(func[3*p +: 3]), 32'(w[2:0]));
        chk("R2 pull_dir_o", 32'(pdir[2*p +: 2]), 32'(w[8:7]));
        chk("R2 pull_str_o", 32'(pstr[2*p +: 2]), 32'(w[10:9]));
        chk("R2 open_drain_o", 32'(od[p]), 32'(w[31]));
      end
    end

    // R3/R5/R6/R7/R10: value word crossed with open-drain and function match
    pad_in = '0;
    for (int p = 0; p < NP; p++) begin
      for (int o = 0; o < 2; o++) begin
        for (int m = 0; m < 2; m++) begin
          logic [2:0] f;
          f = CODES[3*p +: 3] ^ (m == 0 ? 3'd0 : 3'd1);
          wr(ca(p), {o[0], 28'b0, f});
          for (int v = 0; v < 8; v++) begin
            logic lvl, oen, ien, gm, drv;
            lvl = v[0]; oen = v[1]; ien = v[2]; gm = (m == 0);
            drv = gm && !oen && !(o[0] && lvl);
            wr(va(p), 32'hFFFF_FFF8 | 32'(v));
            rd(va(p), d);
            chk("R3 val readback", d, {29'b0, ien, oen, ien ? lvl : 1'b0});
            chk("R5 pad_out_o", 32'(pad_out[p]), 32'(lvl));
            if (o == 1) chk("R6 open-drain oe", 32'(pad_oe_n[p]), 32'(!drv));
            else if (p == 3) chk("R10 code-1 pad oe", 32'(pad_oe_n[p]), 32'(!drv));
            else chk("R5 pad_oe_no", 32'(pad_oe_n[p]), 32'(!drv));
            chk("R7 pad_ie_no", 32'(pad_ie_n[p]), 32'(!(gm && !ien)));
          end
        end
      end
    end

    // R8: two-edge input latency and level readback when input disabled
    wr(ca(1), 32'h0);
    wr(va(1), 32'h2);
    @(negedge clk);
    addr = va(1); pad_in[1] = 1'b1;
    @(negedge clk); #1 chk("R8 after one edge", 32'(rdata[0]), 32'h0);
    @(negedge clk); #1 chk("R8 after two edges", 32'(rdata[0]), 32'h1);
    pad_in[1] = 1'b0;
    @(negedge clk); #1 chk("R8 fall after one edge", 32'(rdata[0]), 32'h1);
    @(negedge clk); #1 chk("R8 fall after two edges", 32'(rdata[0]), 32'h0);
    pad_in[1] = 1'b1;
    wr(va(1), 32'h4);
    repeat (3) @(negedge clk);
    rd(va(1), d); chk("R8 disabled returns level 0", d, 32'h4);
    pad_in[1] = 1'b0;
    wr(va(1), 32'h5);
    repeat (3) @(negedge clk);
    rd(va(1), d); chk("R8 disabled returns level 1", d, 32'h5);

    // R1: distinct words per pad, no crosstalk
    for (int p = 0; p < NP; p++) begin
      cw[p] = (32'h8000_0000 * 32'(p & 1)) | 32'(p << 9) | 32'((p + 1) & 3) << 7 | 32'(p);
      vw[p] = 32'((p + 3) % 8);
      wr(ca(p), cw[p]);
      wr(va(p), vw[p]);
    end
    pad_in = '0;
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      rd(ca(p), d); chk("R1 conf per pad", d, cw[p]);
      rd(va(p), d); chk("R1 val per pad", d, vw[p][2] ? vw[p] : (vw[p] & 32'h6));
    end

    // R9: unmapped offsets
    begin
      logic [AW-1:0] bad [6];
      bad = '{8'h04, 8'h0C, 8'h01, 8'h19, 8'h40, 8'h48};
      foreach (bad[i]) begin
        wr(bad[i], 32'hFFFF_FFFF);
        rd(bad[i], d); chk("R9 unmapped read", d, 32'h0);
      end
    end
    for (int p = 0; p < NP; p++) begin
      rd(ca(p), d); chk("R9 conf untouched", d, cw[p]);
      rd(va(p), d); chk("R9 val untouched", d, vw[p][2] ? vw[p] : (vw[p] & 32'h6));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule